// File: doc/BRIEF.md
# Registered Shifter with Carry and Extend Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically by a count taken from the low six bits of a count input. Alongside the shifted word it produces a carry flag and an extend flag. Both flags hold the last bit that left the word. Counts of zero, exactly the word width, and beyond the word width each follow a fixed rule. This allows a processor's execute stage to hand any 6-bit count to the block without first clamping it.

A zero count leaves the operand untouched and passes the caller's previous carry through to both flags. One shift-type code is reserved, and it behaves as a pass-through in the same way. All outputs are registered. A request marked valid on one clock edge shows its result after that edge, with a valid strobe. The outputs hold their value while no request is offered.

Top module: `shift_carry_unit`

## Requirements
- R1: Only count bits [5:0] are used; setting any of count bits [7:6] changes neither the result nor the flags.
- R2: With a count of zero, the result equals the operand and the carry equals the previous-carry input, for every shift type.
- R3: Shift type 00 (logical left) with count n in 1..31 gives the operand shifted left n places with zeros entering at bit 0, and the carry equals operand bit (32 - n).
- R4: Shift type 01 (logical right) with count n in 1..31 gives the operand shifted right n places with zeros entering at bit 31, and the carry equals operand bit (n - 1).
- R5: Shift type 10 (arithmetic right) with count n in 1..31 gives the operand shifted right n places with copies of bit 31 entering, and the carry equals operand bit (n - 1).
- R6: A logical shift by exactly 32 gives a zero result. The carry is operand bit 0 for type 00 and operand bit 31 for type 01.
- R7: A logical shift (type 00 or 01) by a count of 33 to 63 gives a zero result and a zero carry.
- R8: An arithmetic right shift by a count of 32 to 63 gives a result with every bit equal to operand bit 31, and a carry equal to operand bit 31.
- R9: The extend output equals the carry output after every accepted request.
- R10: Shift type 11 is a pass-through: the result equals the operand and the carry equals the previous-carry input, whatever the count.
- R11: A request with in_valid high at a clock edge appears on the outputs after that edge with out_valid high. With in_valid low, out_valid is low after the edge and result and flags keep their values.
- R12: While rst_n is low at a clock edge, all outputs become zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_data | input | 32 | Operand to shift |
| in_count | input | 8 | Shift count; only bits [5:0] are used |
| in_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 pass-through |
| in_carry_prev | input | 1 | Previous carry flag, returned when nothing is shifted |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 32 | Shifted result |
| out_carry | output | 1 | Last bit shifted out |
| out_extend | output | 1 | Copy of the carry |

## Verification
The hardest cases to reach are the ones where the carry comes from something other than the operand: a zero count, or the reserved type. In these cases the flag must follow the previous-carry input. A design that always takes the carry from the shift would still produce the right word. The stimulus therefore drives each of these requests twice with opposite previous-carry values. It also makes the operand's outgoing bits disagree with the previous-carry input, so only the correct source gives the expected flag. Counts with bits 7:6 set are mixed in so that a zero low field is reached through a large raw count.

// File: rtl/shift_carry_pkg.sv
// Shared shift-type encoding for the shifter and its checker.
// Assumes a two-bit type field; code 3 is reserved and passes data through.
package shift_carry_pkg;
    typedef enum logic [1:0] {
        SK_LSL  = 2'b00,
        SK_LSR  = 2'b01,
        SK_ASR  = 2'b10,
        SK_PASS = 2'b11
    } shift_kind_e;
endpackage

// File: rtl/shift_lanes.sv
// Computes all three shift variants in parallel on a double-width lane,
// so the bit leaving the word lands at a fixed position for any count.
// Assumes AMT_W bits of count and a count never above 2*DATA_W-1.
module shift_lanes #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] val,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] lsl_res,
    output logic              lsl_cf,
    output logic [DATA_W-1:0] lsr_res,
    output logic              lsr_cf,
    output logic [DATA_W-1:0] asr_res,
    output logic              asr_cf
);
    localparam int WIDE_W = 2 * DATA_W;

    logic [WIDE_W-1:0] wide_l;
    logic [WIDE_W-1:0] wide_r;
    logic [WIDE_W-1:0] wide_a;
    logic              unused_lanes;

    // Left lane: operand in the low half, carry appears at bit DATA_W.
    always_comb begin
        wide_l = {{DATA_W{1'b0}}, val} << amt;
    end

    // Right lanes: operand in the high half, carry appears at bit DATA_W-1.
    always_comb begin
        wide_r = {val, {DATA_W{1'b0}}} >> amt;
        wide_a = $unsigned($signed({val, {DATA_W{1'b0}}}) >>> amt);
    end

    assign lsl_res = wide_l[DATA_W-1:0];
    assign lsl_cf  = wide_l[DATA_W];
    assign lsr_res = wide_r[WIDE_W-1:DATA_W];
    assign lsr_cf  = wide_r[DATA_W-1];
    assign asr_res = wide_a[WIDE_W-1:DATA_W];
    assign asr_cf  = wide_a[DATA_W-1];

    assign unused_lanes = ^{wide_l[WIDE_W-1:DATA_W+1], wide_r[DATA_W-2:0], wide_a[DATA_W-2:0]};
endmodule

// File: rtl/shift_select.sv
// Chooses the lane named by the shift type and applies the zero-count rule.
// A zero count or the reserved type returns the operand and the old carry.
module shift_select
    import shift_carry_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] val,
    input  logic [AMT_W-1:0]  amt,
    input  logic [1:0]        kind,
    input  logic              carry_prev,
    input  logic [DATA_W-1:0] lsl_res,
    input  logic              lsl_cf,
    input  logic [DATA_W-1:0] lsr_res,
    input  logic              lsr_cf,
    input  logic [DATA_W-1:0] asr_res,
    input  logic              asr_cf,
    output logic [DATA_W-1:0] res,
    output logic              cf
);
    // Lane mux with the zero-count and pass-through overrides.
    always_comb begin
        res = val;
        cf  = carry_prev;
        if (amt != '0) begin
            case (shift_kind_e'(kind))
                SK_LSL:  begin res = lsl_res; cf = lsl_cf; end
                SK_LSR:  begin res = lsr_res; cf = lsr_cf; end
                SK_ASR:  begin res = asr_res; cf = asr_cf; end
                default: begin res = val;     cf = carry_prev; end
            endcase
        end
    end
endmodule

// File: rtl/shift_out_reg.sv
// Output stage: captures result and flags on a valid request, holds otherwise.
// Synchronous active-low reset clears every output.
module shift_out_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] res,
    input  logic              cf,
    output logic              q_valid,
    output logic [DATA_W-1:0] q_data,
    output logic              q_carry,
    output logic              q_extend
);
    // Valid strobe follows the request by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= load;
    end

    // Data and flags load on a request and hold between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data   <= '0;
            q_carry  <= 1'b0;
            q_extend <= 1'b0;
        end else if (load) begin
            q_data   <= res;
            q_carry  <= cf;
            q_extend <= cf;
        end
    end
endmodule

// File: rtl/shift_carry_unit.sv
// Top: single-cycle shifter with carry and extend flags and registered outputs.
// Assumes CNT_W >= AMT_W; count bits above AMT_W are ignored.
module shift_carry_unit #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CNT_W-1:0]  in_count,
    input  logic [1:0]        in_kind,
    input  logic              in_carry_prev,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_carry,
    output logic              out_extend
);
    localparam int AMT_W = $clog2(DATA_W) + 1;

    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] lsl_res, lsr_res, asr_res, sel_res;
    logic              lsl_cf, lsr_cf, asr_cf, sel_cf;
    logic              unused_cnt_hi;

    assign amt = in_count[AMT_W-1:0];

    // Keep the ignored count bits visible as deliberately unused.
    generate
        if (CNT_W > AMT_W) begin : g_cnt_hi
            assign unused_cnt_hi = ^in_count[CNT_W-1:AMT_W];
        end else begin : g_cnt_exact
            assign unused_cnt_hi = 1'b0;
        end
    endgenerate

    shift_lanes #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_lanes (
        .val(in_data), .amt(amt),
        .lsl_res(lsl_res), .lsl_cf(lsl_cf),
        .lsr_res(lsr_res), .lsr_cf(lsr_cf),
        .asr_res(asr_res), .asr_cf(asr_cf)
    );

    shift_select #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_select (
        .val(in_data), .amt(amt), .kind(in_kind), .carry_prev(in_carry_prev),
        .lsl_res(lsl_res), .lsl_cf(lsl_cf),
        .lsr_res(lsr_res), .lsr_cf(lsr_cf),
        .asr_res(asr_res), .asr_cf(asr_cf),
        .res(sel_res), .cf(sel_cf)
    );

    shift_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(in_valid),
        .res(sel_res), .cf(sel_cf),
        .q_valid(out_valid), .q_data(out_data),
        .q_carry(out_carry), .q_extend(out_extend)
    );
endmodule

// File: rtl/shift_carry_chk.sv
// Checker for shift_carry_unit: relates each request to the registered outputs.
// Assumes outputs reflect the request seen at the previous edge.
module shift_carry_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [CNT_W-1:0]  in_count,
    input logic [1:0]        in_kind,
    input logic              in_carry_prev,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_carry,
    input logic              out_extend
);
    localparam int AMT_W = $clog2(DATA_W) + 1;

    logic [AMT_W-1:0] amt;
    logic             unused_chk_hi;
    assign amt = in_count[AMT_W-1:0];
    assign unused_chk_hi = ^in_count;

    // R2
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && amt == '0) |=>
        (out_data == $past(in_data) && out_carry == $past(in_carry_prev)));

    // R7
    logical_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && !in_kind[1] && amt > DATA_W) |=>
        (out_data == '0 && !out_carry));

    // R8
    arith_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && in_kind == 2'b10 && amt >= DATA_W) |=>
        (out_data == {DATA_W{$past(in_data[DATA_W-1])}} && out_carry == $past(in_data[DATA_W-1])));

    // R9
    extend_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_extend == out_carry));

    // R10
    pass_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && in_kind == 2'b11) |=>
        (out_data == $past(in_data) && out_carry == $past(in_carry_prev)));

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (out_valid == $past(in_valid)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> ($stable(out_data) && $stable(out_carry)));
endmodule

bind shift_carry_unit shift_carry_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_count(in_count), .in_kind(in_kind), .in_carry_prev(in_carry_prev),
    .out_valid(out_valid), .out_data(out_data),
    .out_carry(out_carry), .out_extend(out_extend)
);

// File: tb/shift_carry_unit_bench.sv
module shift_carry_unit_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] v;
        logic [7:0]  c;
        logic [1:0]  k;
        logic        p;
        logic [31:0] r;
        logic        cf;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{32'h8000_0001, 8'd1,    2'b00, 1'b0, 32'h0000_0002, 1'b1, 8'd3},  // R3
        '{32'h4000_0000, 8'd2,    2'b00, 1'b0, 32'h0000_0000, 1'b1, 8'd3},  // R3
        '{32'h1234_5678, 8'd4,    2'b00, 1'b0, 32'h2345_6780, 1'b1, 8'd3},  // R3
        '{32'h0000_0003, 8'd1,    2'b01, 1'b0, 32'h0000_0001, 1'b1, 8'd4},  // R4
        '{32'h8000_0000, 8'd31,   2'b01, 1'b1, 32'h0000_0001, 1'b0, 8'd4},  // R4
        '{32'h8000_0010, 8'd4,    2'b10, 1'b1, 32'hF800_0001, 1'b0, 8'd5},  // R5
        '{32'h7FFF_FFFF, 8'd31,   2'b10, 1'b0, 32'h0000_0000, 1'b1, 8'd5},  // R5
        '{32'h0000_0001, 8'd32,   2'b00, 1'b0, 32'h0000_0000, 1'b1, 8'd6},  // R6
        '{32'h8000_0000, 8'd32,   2'b01, 1'b0, 32'h0000_0000, 1'b1, 8'd6},  // R6
        '{32'hFFFF_FFFF, 8'd33,   2'b00, 1'b1, 32'h0000_0000, 1'b0, 8'd7},  // R7
        '{32'hFFFF_FFFF, 8'd63,   2'b01, 1'b1, 32'h0000_0000, 1'b0, 8'd7},  // R7
        '{32'h8000_0000, 8'd32,   2'b10, 1'b0, 32'hFFFF_FFFF, 1'b1, 8'd8},  // R8
        '{32'h7000_0000, 8'd40,   2'b10, 1'b1, 32'h0000_0000, 1'b0, 8'd8},  // R8
        '{32'hC000_0000, 8'd63,   2'b10, 1'b0, 32'hFFFF_FFFF, 1'b1, 8'd8},  // R8
        '{32'hDEAD_BEEF, 8'd0,    2'b00, 1'b1, 32'hDEAD_BEEF, 1'b1, 8'd2},  // R2
        '{32'hFFFF_FFFF, 8'd0,    2'b10, 1'b0, 32'hFFFF_FFFF, 1'b0, 8'd2},  // R2
        '{32'h0000_0001, 8'h41,   2'b00, 1'b1, 32'h0000_0002, 1'b0, 8'd1},  // R1
        '{32'h8000_0001, 8'hC0,   2'b01, 1'b0, 32'h8000_0001, 1'b0, 8'd1},  // R1
        '{32'h8000_0001, 8'h80,   2'b01, 1'b1, 32'h8000_0001, 1'b1, 8'd1},  // R1
        '{32'h0000_55AA, 8'd5,    2'b11, 1'b1, 32'h0000_55AA, 1'b1, 8'd10}, // R10
        '{32'hFFFF_FFFF, 8'd1,    2'b11, 1'b0, 32'hFFFF_FFFF, 1'b0, 8'd10}, // R10
        '{32'h0000_0001, 8'd31,   2'b00, 1'b1, 32'h8000_0000, 1'b0, 8'd3}   // R3
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_data;
    logic [7:0]  in_count;
    logic [1:0]  in_kind;
    logic        in_carry_prev;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_carry;
    logic        out_extend;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    shift_carry_unit u_shift_carry_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_count(in_count), .in_kind(in_kind), .in_carry_prev(in_carry_prev),
        .out_valid(out_valid), .out_data(out_data),
        .out_carry(out_carry), .out_extend(out_extend)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] v, input logic [7:0] c, input logic [1:0] k, input logic p);
        in_valid = 1'b1; in_data = v; in_count = c; in_kind = k; in_carry_prev = p;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_count = '0; in_kind = '0; in_carry_prev = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check(12, "reset valid",  {31'd0, out_valid},  32'd0);
        check(12, "reset data",   out_data,            32'd0);
        check(12, "reset carry",  {31'd0, out_carry},  32'd0);
        check(12, "reset extend", {31'd0, out_extend}, 32'd0);
        rst_n = 1'b1;

        // Vector walk: each request checked one edge later (R9 on every vector)
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].v, VECS[i].c, VECS[i].k, VECS[i].p);
            @(negedge clk);
            check(int'(VECS[i].req), "data",  out_data, VECS[i].r);
            check(int'(VECS[i].req), "carry", {31'd0, out_carry}, {31'd0, VECS[i].cf});
            check(9, "extend", {31'd0, out_extend}, {31'd0, VECS[i].cf});
            check(11, "valid", {31'd0, out_valid}, 32'd1);
        end

        // R11: idle cycle holds last result (0x80000000, carry 0)
        in_valid = 1'b0; in_data = 32'h1111_1111; in_count = 8'd1; in_kind = 2'b00; in_carry_prev = 1'b1;
        @(negedge clk);
        check(11, "idle valid", {31'd0, out_valid}, 32'd0);
        check(11, "idle hold data", out_data, 32'h8000_0000);
        check(11, "idle hold carry", {31'd0, out_carry}, 32'd0);

        // R2: zero count with each previous-carry value, reached after idle
        drive(32'h0F0F_0F0F, 8'd0, 2'b01, 1'b1);
        @(negedge clk);
        check(2, "zero count carry", {31'd0, out_carry}, 32'd1);
        check(2, "zero count data", out_data, 32'h0F0F_0F0F);

        // R12: reset mid-run clears nonzero outputs
        drive(32'hFFFF_FFFF, 8'd32, 2'b10, 1'b0);
        @(negedge clk);
        check(8, "pre-reset data", out_data, 32'hFFFF_FFFF);
        rst_n = 1'b0;
        @(negedge clk);
        check(12, "mid reset data", out_data, 32'd0);
        check(12, "mid reset carry", {31'd0, out_carry}, 32'd0);
        check(12, "mid reset valid", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule